// File: doc/BRIEF.md
# Byte-Wide SPI Master with Register Port

This peripheral drives an SPI bus as master and is programmed through three byte-wide registers: control, status and data. Software sets the shift clock rate, clock polarity, clock phase and bit order in the control register, then writes a byte to the data register. When the peripheral is both enabled and set to master, that write starts an 8-bit full-duplex exchange. The byte is sent on MOSI while a byte is collected from MISO. When the exchange finishes, the received byte replaces the data register contents, a completion flag is raised and an interrupt may be requested.

A data write that arrives while an exchange is running is refused and raises a collision flag. Acknowledging the interrupt clears the completion flag in hardware. Clearing the enable bit during an exchange aborts it.

The exchange is sequenced by a three-state machine. ST_IDLE holds SCK at its idle level. ST_HALF_IDLE is the first half of a bit with SCK at the idle level. ST_HALF_ACTIVE is the second half with SCK at the opposite level. The transitions are:
- start: ST_IDLE to ST_HALF_IDLE, on an accepted data write.
- leading edge: ST_HALF_IDLE to ST_HALF_ACTIVE, on a timer tick.
- trailing edge: ST_HALF_ACTIVE to ST_HALF_IDLE, on a tick while bits remain.
- finish: ST_HALF_ACTIVE to ST_IDLE, on the tick of the eighth trailing edge.
- abort: from any state to ST_IDLE, when the enable bit is low.

Top module: `spi_master_regs`

## Requirements
- R1: After reset the control, status and data registers read 0x00, SCK is low and the interrupt request is low.
- R2: Address 0 is control, address 1 is status and address 2 is data. Control bits, from bit 7 down to bit 0, are: interrupt enable, enable, LSB-first, master, polarity, phase, rate[1:0]. All control bits read back as written. In status, bit 7 is transfer complete, bit 6 is write collision and bit 0 is double speed. Only bit 0 of status is writable; the rest reads 0.
- R3: A data write starts an exchange only when both enable and master are 1. Otherwise the value is just stored in the data register and SCK does not toggle.
- R4: Each SCK half-period lasts H system clocks. For rate codes 00, 01, 10 and 11, H is 1, 4, 16 and 32, so the SCK period is 2, 8, 32 or 64 clocks. With double speed set, H is halved to 1, 2, 8 and 16; code 00 cannot go faster than 1. The completion flag reads 1 exactly 16*H clocks after the edge that accepts the data write, and reads 0 one clock earlier.
- R5: SCK idles at the polarity bit and makes 8 leading edges per exchange. With phase 0, MOSI/MISO are valid before the leading edge and sampled on it. With phase 1, they change on the leading edge and are sampled on the trailing edge.
- R6: With LSB-first set to 1, bit 0 is shifted first on both lines. With it set to 0, bit 7 is shifted first.
- R7: At completion the data register holds the byte received from MISO, and the completion flag is set.
- R8: The interrupt request is high exactly while the completion flag and interrupt enable are both 1.
- R9: A pulse on the interrupt acknowledge input clears the completion flag.
- R10: A data write during an exchange sets the collision flag, leaves the data register unchanged and does not disturb the bytes in flight.
- R11: An accepted data write clears both the completion and the collision flags.
- R12: Clearing enable during an exchange returns the block to idle within two clocks. SCK goes to its idle level, completion is never flagged and the data register keeps the written byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register select (0 control, 1 status, 2 data) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected register (combinational) |
| irq | output | 1 | Interrupt request |
| irq_ack | input | 1 | Interrupt acknowledge pulse |
| sck | output | 1 | SPI shift clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
Two conditions are hard to reach from the ports: a data write that lands inside a running exchange, and a disable that arrives mid-byte. Both need a register access placed inside a narrow window. The bench widens that window by running the slow rate codes, where an exchange lasts 64 or 512 clocks, and then counts clocks from the accepting write to place the second access in the middle of a bit. A bench-side slave model tracks SCK edges in each of the four polarity/phase modes. From the same model the bench checks the byte the master shifted out, the byte it took in and the number of leading edges.

// File: rtl/spi_master_pkg.sv
package spi_master_pkg;

    localparam int BYTE_W = 8;
    localparam int HALF_W = 6;

    localparam logic [1:0] ADDR_CTRL = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_DATA = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE        = 2'd0,
        ST_HALF_IDLE   = 2'd1,
        ST_HALF_ACTIVE = 2'd2
    } xfer_state_t;

    // bit 7 down to bit 0
    typedef struct packed {
        logic       irq_en;
        logic       enable;
        logic       lsb_first;
        logic       master;
        logic       cpol;
        logic       cpha;
        logic [1:0] rate;
    } ctrl_reg_t;

    // half-period of SCK in system clocks
    function automatic logic [HALF_W-1:0] half_period(input logic [1:0] rate, input logic dbl);
        logic [HALF_W-1:0] h;
        unique case (rate)
            2'b00: h = HALF_W'(1);
            2'b01: h = HALF_W'(4);
            2'b10: h = HALF_W'(16);
            default: h = HALF_W'(32);
        endcase
        if (dbl && h > HALF_W'(1))
            h = h >> 1;
        return h;
    endfunction

endpackage

// File: rtl/spi_rate_timer.sv
module spi_rate_timer #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] half,
    output logic         tick
);
    logic [W-1:0] cnt_q;

    assign tick = run && (cnt_q >= (half - W'(1)));

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + W'(1);
    end
endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_master_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              abort,
    input  logic              tick,
    input  logic [DATA_W-1:0] tx_word,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              busy,
    output logic              sck,
    output logic              mosi,
    output logic              done,
    output logic [DATA_W-1:0] rx_word
);
    localparam int IDX_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(DATA_W - 1);

    xfer_state_t       state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] tx_q, rx_q, rx_merge;
    logic              mosi_q;
    logic              lead, trail, last_trail, sample_now;

    function automatic logic [IDX_W-1:0] bit_pos(input logic [IDX_W-1:0] i, input logic lsb);
        return lsb ? i : (LAST - i);
    endfunction

    assign lead       = (state_q == ST_HALF_IDLE) && tick && !abort;
    assign trail      = (state_q == ST_HALF_ACTIVE) && tick && !abort;
    assign last_trail = trail && (idx_q == LAST);
    assign sample_now = cpha ? trail : lead;

    always_comb begin
        rx_merge = rx_q;
        if (sample_now)
            rx_merge[bit_pos(idx_q, lsb_first)] = miso;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start) state_d = ST_HALF_IDLE;
            ST_HALF_IDLE:   if (tick) state_d = ST_HALF_ACTIVE;
            ST_HALF_ACTIVE: if (tick) state_d = (idx_q == LAST) ? ST_IDLE : ST_HALF_IDLE;
            default:        state_d = ST_IDLE;
        endcase
        if (abort)
            state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // datapath and line outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx_q  <= '0;
            tx_q   <= '0;
            rx_q   <= '0;
            mosi_q <= 1'b0;
        end else if (state_q == ST_IDLE) begin
            if (start && !abort) begin
                tx_q  <= tx_word;
                idx_q <= '0;
                rx_q  <= '0;
                if (!cpha)
                    mosi_q <= tx_word[bit_pos('0, lsb_first)];
            end
        end else begin
            if (sample_now)
                rx_q <= rx_merge;
            if (lead && cpha)
                mosi_q <= tx_q[bit_pos(idx_q, lsb_first)];
            if (trail && (idx_q != LAST)) begin
                idx_q <= idx_q + IDX_W'(1);
                if (!cpha)
                    mosi_q <= tx_q[bit_pos(idx_q + IDX_W'(1), lsb_first)];
            end
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign sck     = (state_q == ST_HALF_ACTIVE) ? ~cpol : cpol;
    assign mosi    = mosi_q;
    assign done    = last_trail;
    assign rx_word = rx_merge;

    // R12
    abort_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (state_q == ST_IDLE));

    // R7
    finish_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);
endmodule

// File: rtl/spi_master_regs.sv
module spi_master_regs
    import spi_master_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       irq,
    input  logic       irq_ack,
    output logic       sck,
    output logic       mosi,
    input  logic       miso
);
    ctrl_reg_t         ctrl_q;
    logic              dbl_q, spif_q, wcol_q;
    logic [BYTE_W-1:0] data_q, rx_word;
    logic              busy, done, tick, abort;
    logic              wr_data, accept, collide;
    logic [HALF_W-1:0] half;

    assign abort   = !ctrl_q.enable;
    assign wr_data = bus_wr && (bus_addr == ADDR_DATA);
    assign accept  = wr_data && !busy && ctrl_q.enable && ctrl_q.master;
    assign collide = wr_data && busy;
    assign half    = half_period(ctrl_q.rate, dbl_q);

    spi_rate_timer #(.W(HALF_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy),
        .half  (half),
        .tick  (tick)
    );

    spi_shift_fsm #(.DATA_W(BYTE_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (accept),
        .abort     (abort),
        .tick      (tick),
        .tx_word   (bus_wdata),
        .cpol      (ctrl_q.cpol),
        .cpha      (ctrl_q.cpha),
        .lsb_first (ctrl_q.lsb_first),
        .miso      (miso),
        .busy      (busy),
        .sck       (sck),
        .mosi      (mosi),
        .done      (done),
        .rx_word   (rx_word)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            dbl_q  <= 1'b0;
            data_q <= '0;
            spif_q <= 1'b0;
            wcol_q <= 1'b0;
        end else begin
            if (bus_wr && bus_addr == ADDR_CTRL)
                ctrl_q <= ctrl_reg_t'(bus_wdata);
            if (bus_wr && bus_addr == ADDR_STAT)
                dbl_q <= bus_wdata[0];
            if (done)
                data_q <= rx_word;
            else if (wr_data && !busy)
                data_q <= bus_wdata;
            if (done)
                spif_q <= 1'b1;
            else if (irq_ack || accept)
                spif_q <= 1'b0;
            if (collide)
                wcol_q <= 1'b1;
            else if (accept)
                wcol_q <= 1'b0;
        end
    end

    always_comb begin
        unique case (bus_addr)
            ADDR_CTRL: bus_rdata = ctrl_q;
            ADDR_STAT: bus_rdata = {spif_q, wcol_q, 5'b0, dbl_q};
            ADDR_DATA: bus_rdata = data_q;
            default:   bus_rdata = '0;
        endcase
    end

    assign irq = spif_q && ctrl_q.irq_en;

    // R10
    collision_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        collide |=> wcol_q);

    // R3
    start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !done) |=> !spif_q);

    // R8
    done_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ctrl_q.irq_en && !(bus_wr && bus_addr == ADDR_CTRL)) |=> irq);

    // R12
    disable_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !ctrl_q.enable) |=> !busy);

    // R11
    accept_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!spif_q && !wcol_q));
endmodule

// File: tb/tb_spi_master_regs.sv
module tb_spi_master_regs;
    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       irq_ack = 1'b0;
    logic       sck, mosi;
    logic       miso = 1'b0;

    int n_total = 0;
    int n_fail  = 0;

    spi_master_regs dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .irq_ack(irq_ack),
        .sck(sck), .mosi(mosi), .miso(miso)
    );

    always #(CLK_P/2) clk = ~clk;

    // slave model
    logic       s_active = 1'b0;
    logic       s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0;
    logic [7:0] s_tx = 8'h00, s_rx = 8'h00;
    int         s_idx = 0;
    int         lead_cnt = 0;

    function automatic int pos(input int i, input logic lsb);
        return lsb ? i : 7 - i;
    endfunction

    always @(sck) begin
        if (s_active) begin
            if (sck != s_cpol) begin
                lead_cnt++;
                if (!s_cpha) begin
                    if (s_idx < 8) s_rx[pos(s_idx, s_lsb)] = mosi;
                end else begin
                    if (s_idx < 8) miso = s_tx[pos(s_idx, s_lsb)];
                end
            end else begin
                if (!s_cpha) begin
                    s_idx++;
                    if (s_idx < 8) miso = s_tx[pos(s_idx, s_lsb)];
                end else begin
                    if (s_idx < 8) s_rx[pos(s_idx, s_lsb)] = mosi;
                    s_idx++;
                end
            end
        end
    end

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] mk(input logic ie, input logic en, input logic lsb,
                                      input logic ms, input logic pol, input logic pha,
                                      input logic [1:0] rate);
        return {ie, en, lsb, ms, pol, pha, rate};
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic arm(input logic pol, input logic pha, input logic lsb, input logic [7:0] stx);
        s_cpol = pol; s_cpha = pha; s_lsb = lsb; s_tx = stx;
        s_idx = 0; s_rx = 8'h00; lead_cnt = 0;
        miso = stx[pos(0, lsb)];
        s_active = 1'b1;
    endtask

    task automatic wait_done(output logic ok);
        logic [7:0] v;
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd1, v);
            if (v[7]) begin ok = 1'b1; break; end
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        rd(2'd0, v); chk(v == 8'h00, "R1 ctrl", v, 0);
        rd(2'd1, v); chk(v == 8'h00, "R1 status", v, 0);
        rd(2'd2, v); chk(v == 8'h00, "R1 data", v, 0);
        chk(sck == 1'b0, "R1 sck", sck, 0);
        chk(irq == 1'b0, "R1 irq", irq, 0);
        @(negedge clk);
    endtask

    task automatic t_layout();
        logic [7:0] v;
        wr(2'd0, 8'hBD); rd(2'd0, v); chk(v == 8'hBD, "R2 ctrl readback", v, 8'hBD);
        @(negedge clk);
        wr(2'd1, 8'hFF); rd(2'd1, v); chk(v == 8'h01, "R2 status writable bits", v, 1);
        @(negedge clk);
        wr(2'd1, 8'h00); wr(2'd0, 8'h00);
    endtask

    task automatic t_gate(input logic en, input logic ms, input logic [7:0] d);
        logic [7:0] v;
        wr(2'd0, mk(0, en, 0, ms, 0, 0, 2'b00));
        arm(0, 0, 0, 8'h00);
        wr(2'd2, d);
        repeat (60) @(negedge clk);
        chk(lead_cnt == 0, "R3 no sck edges", lead_cnt, 0);
        rd(2'd1, v); chk(v[7] == 1'b0, "R3 no completion", v, 0);
        rd(2'd2, v); chk(v == d, "R3 data stored", v, d);
        s_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_xfer(input logic pol, input logic pha, input logic lsb,
                          input logic [1:0] rate, input logic dbl,
                          input logic [7:0] mtx, input logic [7:0] stx);
        logic [7:0] v;
        logic ok;
        wr(2'd0, mk(0, 1, lsb, 1, pol, pha, rate));
        wr(2'd1, {7'b0, dbl});
        chk(sck == pol, "R5 idle level", sck, pol);
        arm(pol, pha, lsb, stx);
        wr(2'd2, mtx);
        wait_done(ok);
        chk(ok, "R7 completion flag", ok, 1);
        rd(2'd2, v); chk(v == stx, "R7 R6 received byte", v, stx);
        chk(s_rx == mtx, "R5 R6 sent byte", s_rx, mtx);
        chk(lead_cnt == 8, "R5 leading edges", lead_cnt, 8);
        @(negedge clk);
        chk(sck == pol, "R5 back to idle", sck, pol);
        s_active = 1'b0;
    endtask

    task automatic t_timing(input logic [1:0] rate, input logic dbl, input int h);
        logic [7:0] v;
        logic ok;
        wr(2'd0, mk(0, 1, 0, 1, 0, 0, rate));
        wr(2'd1, {7'b0, dbl});
        wr(2'd2, 8'h5A);
        repeat (16 * h - 1) @(negedge clk);
        rd(2'd1, v); chk(v[7] == 1'b0, "R4 flag one clock early", v, 0);
        @(negedge clk);
        rd(2'd1, v); chk(v[7] == 1'b1, "R4 flag on time", v, 8'h80);
        wait_done(ok);
        @(negedge clk);
    endtask

    task automatic t_irq();
        logic [7:0] v;
        logic ok;
        wr(2'd1, 8'h00);
        wr(2'd0, mk(1, 1, 0, 1, 0, 0, 2'b00));
        wr(2'd2, 8'hC3);
        chk(irq == 1'b0, "R8 no irq while running", irq, 0);
        wait_done(ok);
        chk(irq == 1'b1, "R8 irq raised", irq, 1);
        @(negedge clk);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        rd(2'd1, v); chk(v[7] == 1'b0, "R9 ack clears flag", v, 0);
        chk(irq == 1'b0, "R9 irq dropped", irq, 0);
        @(negedge clk);
        wr(2'd0, mk(0, 1, 0, 1, 0, 0, 2'b00));
        wr(2'd2, 8'h3C);
        wait_done(ok);
        chk(irq == 1'b0, "R8 masked irq", irq, 0);
        @(negedge clk);
    endtask

    task automatic t_collision();
        logic [7:0] v;
        logic ok;
        wr(2'd1, 8'h00);
        wr(2'd0, mk(0, 1, 0, 1, 0, 1, 2'b01));
        arm(0, 1, 0, 8'h96);
        wr(2'd2, 8'h3C);
        repeat (20) @(negedge clk);
        wr(2'd2, 8'h99);
        rd(2'd1, v); chk(v[6] == 1'b1, "R10 collision flag", v, 8'h40);
        rd(2'd2, v); chk(v == 8'h3C, "R10 data unchanged", v, 8'h3C);
        wait_done(ok);
        rd(2'd2, v); chk(v == 8'h96, "R10 received undisturbed", v, 8'h96);
        chk(s_rx == 8'h3C, "R10 sent undisturbed", s_rx, 8'h3C);
        rd(2'd1, v); chk(v[7:6] == 2'b11, "R10 both flags", v, 8'hC0);
        @(negedge clk);
        arm(0, 1, 0, 8'h11);
        wr(2'd2, 8'h22);
        rd(2'd1, v); chk(v[7:6] == 2'b00, "R11 accept clears flags", v, 0);
        wait_done(ok);
        s_active = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_abort();
        logic [7:0] v;
        wr(2'd1, 8'h00);
        wr(2'd0, mk(0, 1, 0, 1, 1, 0, 2'b11));
        wr(2'd2, 8'hE7);
        repeat (100) @(negedge clk);
        wr(2'd0, mk(0, 0, 0, 1, 1, 0, 2'b11));
        repeat (2) @(negedge clk);
        chk(sck == 1'b1, "R12 sck idle after abort", sck, 1);
        repeat (600) @(negedge clk);
        chk(sck == 1'b1, "R12 sck stays idle", sck, 1);
        rd(2'd1, v); chk(v[7] == 1'b0, "R12 no completion", v, 0);
        rd(2'd2, v); chk(v == 8'hE7, "R12 data kept", v, 8'hE7);
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_layout();
        t_gate(1'b1, 1'b0, 8'hA5);
        t_gate(1'b0, 1'b1, 8'h5A);
        t_xfer(0, 0, 0, 2'b00, 0, 8'hA3, 8'h5C);
        t_xfer(0, 1, 1, 2'b01, 0, 8'h81, 8'h7E);
        t_xfer(1, 0, 1, 2'b00, 1, 8'h0F, 8'hB4);
        t_xfer(1, 1, 0, 2'b10, 1, 8'hD2, 8'h2D);
        t_timing(2'b01, 1'b0, 4);
        t_timing(2'b00, 1'b1, 1);
        t_timing(2'b01, 1'b1, 2);
        t_timing(2'b11, 1'b1, 16);
        t_timing(2'b10, 1'b0, 16);
        t_irq();
        t_collision();
        t_abort();
        wr(2'd0, mk(0, 1, 1, 1, 0, 0, 2'b00));
        t_xfer(0, 0, 1, 2'b00, 0, 8'h12, 8'hEF);
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

    initial begin
        #(CLK_P * 150000);
        n_total++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule